// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block gives software control over a bank of 32 general-purpose pins through a small register bus: a byte address, a write strobe, 32 bits of write data and 32 bits of combinational read data. Three registers set the port up: one chooses which pins drive, one turns individual drivers into open-drain drivers, and one holds the output latch of every pin. The block drives an output value and an output enable for each pin and brings the pin levels in through a two-stage synchronizer.

Pins are numbered from the most significant end of each register: pin n lives in register bit 31 - n. On the pin ports, index n is pin n. A read of the data register gives one word that mixes two sources. Bits of pins that are set to drive return the stored latch. Bits of pins that are inputs return the synchronized pin level. A build parameter fixes the four highest-numbered pins as inputs that can never drive. The bus is assumed to be synchronous to the clock. The reset input is asynchronous, and its release is expected to arrive already aligned to the clock.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted and after it is released, the direction, open-drain and latch registers are all zero, every pin_oe bit is 0 and every pin_out bit is 0.
- R2: The direction register is at byte address 0x0, the open-drain register at 0x4 and the data register at 0x8. A read of any other address returns 0, and a write to any other address changes no register.
- R3: Pin n corresponds to register bit 31 - n in all three registers and in read data, so pin 0 is bit 31 and pin 31 is bit 0.
- R4: A pin whose direction bit is 1 and whose open-drain bit is 0 has pin_oe = 1 and pin_out equal to its latch bit. A pin whose direction bit is 0 has pin_oe = 0.
- R5: A read of the data register returns the latch bit for each pin whose direction bit is 1, and the synchronized input level for each pin whose direction bit is 0. The open-drain bits do not affect it.
- R6: One write to the data register loads all 32 latch bits in that cycle, including the latches of input pins. Those latches keep their value and show on the pins once the pins are made outputs. With no write to the data register, the latches hold.
- R7: A pin whose direction bit and open-drain bit are both 1 has pin_oe = 1 and pin_out = 0 when its latch bit is 0, and pin_oe = 0 when its latch bit is 1.
- R8: With parameter INPUT_ONLY_TOP = 1, the direction bits of pins 28 to 31 (register bits 3 to 0) ignore writes and read as 0, and pin_oe of those pins is always 0.
- R9: A change on pin_in shows in data-register reads after the second rising clock edge, and not after the first one.
- R10: The direction and open-drain registers read back the last value written, apart from the bits held at 0 by R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe; writes bus_wdata at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Pin levels, index n is pin n |
| pin_out | output | 32 | Output value, index n is pin n |
| pin_oe | output | 32 | Output enable, index n is pin n |

## Verification
On every cycle the assertions check the following. Each latch register holds or loads exactly as the write strobe and address decode say. The masked direction bits never become set, and the input-only pins never drive. An open-drain pin whose latch is 1 never enables its driver. The synchronized input equals the pin level from two edges earlier. Other behaviour is shown only by the bench's scenarios and its cycle-level reference model: the MSB-first pin mapping, the mixed read of the data register under changing directions, a latch written while its pin was an input and seen only once the pin drives, and writes to unmapped addresses being ignored.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned REG_W       = 32;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned RO_PINS     = 4;

  localparam logic [ADDR_W-1:0] OFS_DIR = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ODE = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_LAT = 4'h8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_ODE,
    SEL_LAT
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
    reg_sel_e sel;
    case (addr)
      OFS_DIR: sel = SEL_DIR;
      OFS_ODE: sel = SEL_ODE;
      OFS_LAT: sel = SEL_LAT;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/gpio_bit_sync.sv
module gpio_bit_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter bit INPUT_ONLY_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  dir_q,
  output logic [REG_W-1:0]  ode_q,
  output logic [REG_W-1:0]  lat_q
);

  function automatic logic [REG_W-1:0] make_dir_mask();
    logic [REG_W-1:0] m;
    for (int p = 0; p < REG_W; p++) begin
      m[REG_W-1-p] = !(INPUT_ONLY_TOP && (p >= int'(REG_W - RO_PINS)));
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] DIR_WMASK = make_dir_mask();

  logic             dir_en, ode_en, lat_en;
  logic [REG_W-1:0] dir_d, ode_d, lat_d;

  always_comb begin
    dir_en = we && (sel == SEL_DIR);
    ode_en = we && (sel == SEL_ODE);
    lat_en = we && (sel == SEL_LAT);
    dir_d  = dir_en ? (wdata & DIR_WMASK) : dir_q;
    ode_d  = ode_en ? wdata : ode_q;
    lat_d  = lat_en ? wdata : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ode_q <= '0;
      lat_q <= '0;
    end else begin
      dir_q <= dir_d;
      ode_q <= ode_d;
      lat_q <= lat_d;
    end
  end

  // R6: latch holds without a data write
  p_lat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel == SEL_LAT) |=> $stable(lat_q));

  // R6: a data write loads every latch bit at once
  p_lat_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_LAT) |=> (lat_q == $past(wdata)));

  // R8: masked direction bits never set
  p_dir_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & ~DIR_WMASK) == '0);

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
(
  input  logic [REG_W-1:0] dir_q,
  input  logic [REG_W-1:0] ode_q,
  input  logic [REG_W-1:0] lat_q,
  output logic [REG_W-1:0] pin_out,
  output logic [REG_W-1:0] pin_oe
);

  for (genvar p = 0; p < REG_W; p++) begin : g_pin
    localparam int unsigned B = REG_W - 1 - p;
    always_comb begin
      if (ode_q[B]) begin
        pin_out[p] = 1'b0;
        pin_oe[p]  = dir_q[B] && !lat_q[B];
      end else begin
        pin_out[p] = lat_q[B];
        pin_oe[p]  = dir_q[B];
      end
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
(
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] dir_q,
  input  logic [REG_W-1:0] ode_q,
  input  logic [REG_W-1:0] lat_q,
  input  logic [REG_W-1:0] sync_bits,
  output logic [REG_W-1:0] rdata
);

  always_comb begin
    case (sel)
      SEL_DIR: rdata = dir_q;
      SEL_ODE: rdata = ode_q;
      SEL_LAT: rdata = (lat_q & dir_q) | (sync_bits & ~dir_q);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter bit INPUT_ONLY_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  pin_in,
  output logic [REG_W-1:0]  pin_out,
  output logic [REG_W-1:0]  pin_oe
);

  reg_sel_e         sel;
  logic [REG_W-1:0] dir_q, ode_q, lat_q;
  logic [REG_W-1:0] sync_pins;
  logic [REG_W-1:0] sync_bits;

  assign sel = decode_addr(bus_addr);

  gpio_reg_bank #(.INPUT_ONLY_TOP(INPUT_ONLY_TOP)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .we    (bus_we),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .ode_q (ode_q),
    .lat_q (lat_q)
  );

  gpio_bit_sync #(.WIDTH(REG_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (sync_pins)
  );

  // pins are MSB-first in register space
  for (genvar p = 0; p < REG_W; p++) begin : g_reorder
    assign sync_bits[REG_W-1-p] = sync_pins[p];
  end

  gpio_pin_drive u_drive (
    .dir_q   (dir_q),
    .ode_q   (ode_q),
    .lat_q   (lat_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  gpio_read_mux u_rmux (
    .sel       (sel),
    .dir_q     (dir_q),
    .ode_q     (ode_q),
    .lat_q     (lat_q),
    .sync_bits (sync_bits),
    .rdata     (bus_rdata)
  );

  // warm-up counter so the synchronizer check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != 2'(SYNC_DEPTH)) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  // R9: synchronized level equals the pin level two edges earlier
  p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'(SYNC_DEPTH)) |-> (sync_pins == $past(pin_in, SYNC_DEPTH)));

  // R7: an open-drain output with latch 1 never drives
  for (genvar p = 0; p < REG_W; p++) begin : g_od_chk
    p_od_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ode_q[REG_W-1-p] && lat_q[REG_W-1-p]) |-> !pin_oe[p]);
  end

  if (INPUT_ONLY_TOP) begin : g_ro_chk
    // R8: input-only pins never drive
    p_ro_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[REG_W-1 -: RO_PINS] == '0);
  end

endmodule

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  gpio_port_regs #(.INPUT_ONLY_TOP(1'b1)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_dir = '0, m_od = '0, m_lat = '0;
  logic [31:0] hist[$];

  function automatic logic [31:0] dir_allowed();
    logic [31:0] m = '1;
    for (int p = 28; p < 32; p++) m[31-p] = 1'b0;
    return m;
  endfunction

  function automatic logic [31:0] m_sync_reg();
    logic [31:0] s = '0;
    if (hist.size() == 2) begin
      for (int p = 0; p < 32; p++) s[31-p] = hist[0][p];
    end
    return s;
  endfunction

  function automatic logic [31:0] m_rdata(input logic [3:0] a);
    if (a == 4'h0) return m_dir;
    if (a == 4'h4) return m_od;
    if (a == 4'h8) return (m_lat & m_dir) | (m_sync_reg() & ~m_dir);
    return '0;
  endfunction

  function automatic logic [31:0] m_oe();
    logic [31:0] v;
    for (int p = 0; p < 32; p++)
      v[p] = m_dir[31-p] && !(m_od[31-p] && m_lat[31-p]);
    return v;
  endfunction

  function automatic logic [31:0] m_out();
    logic [31:0] v;
    for (int p = 0; p < 32; p++) v[p] = m_lat[31-p] && !m_od[31-p];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = '0; m_od = '0; m_lat = '0;
      hist.delete();
    end else begin
      if (bus_we) begin
        case (bus_addr)
          4'h0: m_dir = bus_wdata & dir_allowed();
          4'h4: m_od  = bus_wdata;
          4'h8: m_lat = bus_wdata;
          default: ;
        endcase
      end
      hist.push_back(pin_in);
      if (hist.size() > 2) void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    chk("R4/R7 model pin_oe", pin_oe, m_oe());
    chk("R4/R7 model pin_out", pin_out, m_out());
    chk("R5 model rdata", bus_rdata, m_rdata(bus_addr));
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pin_oe, 32'h0);
    chk("R1 out in reset", pin_out, 32'h0);
    rst_n = 1'b1;
    rd("R1 dir after reset", 4'h0, 32'h0);
    rd("R1 od after reset", 4'h4, 32'h0);
    rd("R1 data after reset", 4'h8, 32'h0);

    // R8 / R10: direction with masked top pins
    wr(4'h0, 32'hFFFF_FFFF);
    rd("R8 R10 dir readback", 4'h0, 32'hFFFF_FFF0);
    chk("R8 R4 pin_oe", pin_oe, 32'h0FFF_FFFF);

    // R3 / R4 / R5
    wr(4'h8, 32'hA5A5_5A5A);
    chk("R3 pin0 is bit31", {31'h0, pin_out[0]}, 32'h1);
    chk("R3 pin1 is bit30", {31'h0, pin_out[1]}, 32'h0);
    chk("R3 pin30 is bit1", {31'h0, pin_out[30]}, 32'h1);
    rd("R5 mixed read", 4'h8, 32'hA5A5_5A50);

    // R9: two-edge synchronizer on input-only pins 31 and 28
    @(negedge clk);
    pin_in = 32'h9000_0000;
    rd("R9 after one edge", 4'h8, 32'hA5A5_5A50);
    rd("R9 after two edges", 4'h8, 32'hA5A5_5A59);

    // all inputs, pin 0 high
    wr(4'h0, 32'h0);
    pin_in = 32'h0000_0001;
    repeat (2) @(negedge clk);
    rd("R3 R5 pin0 input is bit31", 4'h8, 32'h8000_0000);
    chk("R4 inputs do not drive", pin_oe, 32'h0);

    // R6: latch written while pins are inputs
    wr(4'h8, 32'h0000_FFFF);
    rd("R6 latch hidden while input", 4'h8, 32'h8000_0000);
    wr(4'h0, 32'h0000_FFFF);
    rd("R6 latch shows once output", 4'h8, 32'h8000_FFF0);
    chk("R6 pin16 drives latch", {30'h0, pin_oe[16], pin_out[16]}, 32'h3);

    // R7: open drain
    wr(4'h4, 32'h0000_FFFF);
    rd("R10 od readback", 4'h4, 32'h0000_FFFF);
    chk("R7 od latch1 released", {31'h0, pin_oe[16]}, 32'h0);
    rd("R5 od ignored in read", 4'h8, 32'h8000_FFF0);
    wr(4'h8, 32'h0000_FF00);
    chk("R7 od latch0 drives low", {30'h0, pin_oe[24], pin_out[24]}, 32'h2);
    chk("R7 od latch1 released 2", {31'h0, pin_oe[16]}, 32'h0);
    chk("R8 pin28 never drives", {31'h0, pin_oe[28]}, 32'h0);

    // R2: unmapped addresses
    wr(4'hC, 32'hFFFF_FFFF);
    rd("R2 unmapped read", 4'hC, 32'h0);
    rd("R2 misaligned read", 4'h2, 32'h0);
    rd("R2 dir untouched", 4'h0, 32'h0000_FFF0);
    rd("R2 od untouched", 4'h4, 32'h0000_FFFF);
    rd("R2 data untouched", 4'h8, 32'h8000_FF00);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule